// File: doc/BRIEF.md
# LAN-to-WAN Forwarding Classifier

This block sits between an Ethernet receive MAC and a set of five WAN transmit queues. It takes received frames one byte per accepted clock, strips the 14-byte Ethernet header, and passes every IP byte on toward the queues. It never buffers a whole frame. While the bytes stream through, it captures the header fields it needs: the EtherType, the version nibble, the DSCP, the TTL and the destination address. It lowers the TTL by one and patches the header checksum to match.

When the frame ends, the block issues a single verdict. A commit pulse means the queue writer keeps the bytes it just wrote. A discard pulse means the writer rolls its write pointer back. The destination queue index is presented together with the first IP byte and is held until the verdict. The router's own address, the subnet mask and the per-queue full flags are live inputs.

Top module: `ipfwd_classifier`

## Requirements
- R1: For every frame of length L, exactly max(L-14, 0) bytes appear on `q_data` with `q_valid` high. They are the frame's bytes from offset 14 onward, in order, and unchanged except where R3 and R4 say otherwise.
- R2: A frame is discarded when frame bytes 12 and 13 are not 0x08 and 0x00 (big-endian EtherType 0x0800). It is also discarded when the upper nibble of IP byte 0 (frame offset 14) is not 4.
- R3: A frame whose TTL (IP byte 8) is 0 is discarded. For every other frame, the TTL byte is emitted as the received value minus one.
- R4: IP bytes 10 and 11 (checksum, high byte first) are emitted as the one's-complement checksum recomputed over the 20-byte header after the TTL change.
- R5: A frame with destination address (IP bytes 16 to 19, most significant byte first) equal to 255.255.255.255 is discarded.
- R6: A frame is discarded when (destination AND mask) equals (router address AND mask).
- R7: `q_sel` is taken from the DSCP, which is IP byte 1 bits [7:2]. DSCP 101110 gives queue 4. A DSCP with class bits [5:3] in 1..4, drop bits [2:1] in 1..3 and bit 0 clear gives queue class-1. Every other DSCP gives queue 0. `q_sel` is valid from the first emitted IP byte through the verdict pulse.
- R8: A frame that passes every other rule is discarded when `queue_full[q_sel]` is high in the cycle after its last byte is accepted.
- R9: Exactly one of `q_commit` or `q_discard` pulses for one cycle, in the second cycle after the end-of-frame byte is accepted, together with the last IP byte. Frames shorter than 34 bytes are discarded. After reset, all outputs are low.
- R10: Bytes are accepted only in cycles with `rx_valid` high. Idle cycles inside a frame change neither the emitted bytes nor the verdict.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| rx_data | input | 8 | Received frame byte |
| rx_valid | input | 1 | rx_data carries a byte this cycle |
| rx_sof | input | 1 | Byte is the first of a frame |
| rx_eof | input | 1 | Byte is the last of a frame |
| router_ip | input | 32 | Router's own IPv4 address |
| subnet_mask | input | 32 | LAN subnet mask |
| queue_full | input | 5 | Per-queue full flags, bit n for queue n |
| q_data | output | 8 | IP byte toward the queue |
| q_valid | output | 1 | q_data is valid |
| q_sel | output | 3 | Target queue index |
| q_commit | output | 1 | Keep the frame just written |
| q_discard | output | 1 | Roll back the frame just written |

## Verification
The bench aims at the field boundaries where an off-by-one in the byte-position tracker would patch the wrong byte. That fault shows up as a TTL that is not lowered or a checksum that no longer validates. It also probes the decision edges: TTL of exactly 0 against 1, the all-ones destination, a destination inside the subnet, a full target queue, and a 33-byte runt. A faulty design would commit such frames, or discard good ones. DSCP values cover every AF class and drop level, EF, and near misses with bit 0 set or a drop level of 0. A wrong mapping then sends traffic to the wrong queue. Random idle gaps and back-to-back frames expose any dependence on consecutive valid cycles, and any state that leaks from one frame into the next.

// File: rtl/ipfwd_pkg.sv
package ipfwd_pkg;

   // Frame layout positions (wire format, fixed by the protocol)
   localparam int ETH_HDR_LEN  = 14;
   localparam int ETYPE_HI_POS = 12;
   localparam int ETYPE_LO_POS = 13;
   localparam int IP_VER_OFF   = 0;
   localparam int IP_TOS_OFF   = 1;
   localparam int IP_TTL_OFF   = 8;
   localparam int IP_CSUM_OFF  = 10;
   localparam int IP_DST_OFF   = 16;
   localparam int IP_HDR_LEN   = 20;
   localparam logic [7:0] ETYPE_IPV4_HI = 8'h08;
   localparam logic [7:0] ETYPE_IPV4_LO = 8'h00;

   // DSCP to queue index; ef_code selects the top queue
   function automatic logic [2:0] dscp_to_queue(input logic [5:0] dscp,
                                                input logic [5:0] ef_code);
      logic [2:0] cls;
      logic [1:0] drop;
      cls  = dscp[5:3];
      drop = dscp[2:1];
      if (dscp == ef_code)
         return 3'd4;
      else if (!dscp[0] && cls >= 3'd1 && cls <= 3'd4 && drop != 2'd0)
         return cls - 3'd1;
      else
         return 3'd0;
   endfunction

endpackage

// File: rtl/ipfwd_hdr_track.sv
module ipfwd_hdr_track
   import ipfwd_pkg::*;
#(
   parameter int IDX_W = 11
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [7:0]       rx_data,
   input  logic             rx_valid,
   input  logic             rx_sof,
   output logic [IDX_W-1:0] cur_idx,
   output logic             etype_ok,
   output logic             ver_ok,
   output logic             ttl_zero,
   output logic             long_ok,
   output logic [31:0]      dst_addr
);

   localparam logic [IDX_W-1:0] IDX_MAX  = {IDX_W{1'b1}};
   localparam logic [IDX_W-1:0] P_ETH_HI = IDX_W'(ETYPE_HI_POS);
   localparam logic [IDX_W-1:0] P_ETH_LO = IDX_W'(ETYPE_LO_POS);
   localparam logic [IDX_W-1:0] P_VER    = IDX_W'(ETH_HDR_LEN + IP_VER_OFF);
   localparam logic [IDX_W-1:0] P_TTL    = IDX_W'(ETH_HDR_LEN + IP_TTL_OFF);
   localparam logic [IDX_W-1:0] P_DST0   = IDX_W'(ETH_HDR_LEN + IP_DST_OFF);
   localparam logic [IDX_W-1:0] P_DST3   = IDX_W'(ETH_HDR_LEN + IP_DST_OFF + 3);

   if (IDX_W < 6) begin : g_bad_idx
      $error("IDX_W too small to reach the destination field");
   end

   logic [IDX_W-1:0] idx_q;
   logic             hi_ok_q, lo_ok_q;

   assign cur_idx  = rx_sof ? '0 : idx_q;
   assign etype_ok = hi_ok_q && lo_ok_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         idx_q    <= '0;
         hi_ok_q  <= 1'b0;
         lo_ok_q  <= 1'b0;
         ver_ok   <= 1'b0;
         ttl_zero <= 1'b0;
         long_ok  <= 1'b0;
         dst_addr <= '0;
      end else if (rx_valid) begin
         idx_q <= (cur_idx == IDX_MAX) ? IDX_MAX : cur_idx + 1'b1;
         if (cur_idx == '0) begin
            hi_ok_q <= 1'b0;
            lo_ok_q <= 1'b0;
            ver_ok  <= 1'b0;
            long_ok <= 1'b0;
         end
         if (cur_idx == P_ETH_HI) hi_ok_q  <= (rx_data == ETYPE_IPV4_HI);
         if (cur_idx == P_ETH_LO) lo_ok_q  <= (rx_data == ETYPE_IPV4_LO);
         if (cur_idx == P_VER)    ver_ok   <= (rx_data[7:4] == 4'd4);
         if (cur_idx == P_TTL)    ttl_zero <= (rx_data == 8'd0);
         if (cur_idx >= P_DST0 && cur_idx <= P_DST3)
            dst_addr <= {dst_addr[23:0], rx_data};
         if (cur_idx == P_DST3)   long_ok  <= 1'b1;
      end
   end

   // R10: position counter holds at its ceiling instead of wrapping
   // R10
   idx_sat_chk: assert property (@(posedge clk) disable iff (rst)
      (rx_valid && !rx_sof && idx_q == IDX_MAX) |=> (idx_q == IDX_MAX));

endmodule

// File: rtl/ipfwd_csum_adj.sv
module ipfwd_csum_adj (
   input  logic [15:0] csum_in,
   output logic [15:0] csum_out
);
   // Header sum moves by -0x0100 when TTL (high byte) drops by one:
   // one's-complement add of 0xFEFF to the inverted checksum.
   logic [16:0] raw;
   logic [15:0] folded;

   assign raw      = {1'b0, ~csum_in} + 17'h0FEFF;
   assign folded   = raw[15:0] + {15'd0, raw[16]};
   assign csum_out = ~folded;
endmodule

// File: rtl/ipfwd_classifier.sv
module ipfwd_classifier
   import ipfwd_pkg::*;
#(
   parameter int          IDX_W     = 11,
   parameter int          NUM_Q     = 5,
   parameter logic [5:0]  EF_CODE   = 6'b101110,
   parameter bit          CHECK_VER = 1'b1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [7:0]        rx_data,
   input  logic              rx_valid,
   input  logic              rx_sof,
   input  logic              rx_eof,
   input  logic [31:0]       router_ip,
   input  logic [31:0]       subnet_mask,
   input  logic [4:0]        queue_full,
   output logic [7:0]        q_data,
   output logic              q_valid,
   output logic [2:0]        q_sel,
   output logic              q_commit,
   output logic              q_discard
);

   localparam logic [IDX_W-1:0] P_FIRST = IDX_W'(ETH_HDR_LEN);
   localparam logic [IDX_W-1:0] P_TOS   = IDX_W'(ETH_HDR_LEN + IP_TOS_OFF);
   localparam logic [IDX_W-1:0] P_TTL   = IDX_W'(ETH_HDR_LEN + IP_TTL_OFF);
   localparam logic [IDX_W-1:0] P_CSLO  = IDX_W'(ETH_HDR_LEN + IP_CSUM_OFF + 1);

   if (NUM_Q != 5) begin : g_bad_q
      $error("queue map is built for five queues");
   end

   logic [IDX_W-1:0] cur_idx;
   logic             etype_ok, ver_ok, ttl_zero, long_ok, ver_pass;
   logic [31:0]      dst_addr;
   logic [15:0]      csum_new;
   logic [7:0]       hold_q, emit_byte, store_byte;
   logic             hold_vld_q, flush_q;
   logic             byte_in_ip, emit_now, fwd_ok;

   ipfwd_hdr_track #(.IDX_W(IDX_W)) trk_i (
      .clk(clk), .rst(rst), .rx_data(rx_data), .rx_valid(rx_valid),
      .rx_sof(rx_sof), .cur_idx(cur_idx), .etype_ok(etype_ok),
      .ver_ok(ver_ok), .ttl_zero(ttl_zero), .long_ok(long_ok),
      .dst_addr(dst_addr)
   );

   ipfwd_csum_adj csum_i (
      .csum_in({hold_q, rx_data}),
      .csum_out(csum_new)
   );

   if (CHECK_VER) begin : g_ver
      assign ver_pass = ver_ok;
   end else begin : g_nover
      assign ver_pass = 1'b1;
   end

   assign byte_in_ip = rx_valid && (cur_idx >= P_FIRST);
   assign emit_now   = rx_valid && (cur_idx >  P_FIRST);
   assign emit_byte  = (cur_idx == P_CSLO) ? csum_new[15:8] : hold_q;
   assign store_byte = (cur_idx == P_TTL)  ? rx_data - 8'd1 :
                       (cur_idx == P_CSLO) ? csum_new[7:0]  : rx_data;

   assign fwd_ok = etype_ok && ver_pass && long_ok && !ttl_zero &&
                   (dst_addr != 32'hFFFF_FFFF) &&
                   ((dst_addr & subnet_mask) != (router_ip & subnet_mask)) &&
                   !queue_full[q_sel];

   always_ff @(posedge clk) begin
      if (rst) begin
         q_data     <= '0;
         q_valid    <= 1'b0;
         q_sel      <= '0;
         q_commit   <= 1'b0;
         q_discard  <= 1'b0;
         hold_q     <= '0;
         hold_vld_q <= 1'b0;
         flush_q    <= 1'b0;
      end else begin
         q_valid   <= 1'b0;
         q_commit  <= 1'b0;
         q_discard <= 1'b0;
         flush_q   <= 1'b0;
         if (flush_q) begin
            q_data     <= hold_q;
            q_valid    <= hold_vld_q;
            hold_vld_q <= 1'b0;
            q_commit   <= fwd_ok;
            q_discard  <= !fwd_ok;
         end
         if (rx_valid && rx_sof) hold_vld_q <= 1'b0;
         if (emit_now) begin
            q_data  <= emit_byte;
            q_valid <= 1'b1;
         end
         if (byte_in_ip) begin
            hold_q     <= store_byte;
            hold_vld_q <= 1'b1;
         end
         if (rx_valid && cur_idx == P_TOS)
            q_sel <= dscp_to_queue(rx_data[7:2], EF_CODE);
         if (rx_valid && rx_eof) flush_q <= 1'b1;
      end
   end

   // R9
   verdict_timing_chk: assert property (@(posedge clk) disable iff (rst)
      (rx_valid && rx_eof) |=> ##1 (q_commit || q_discard));

   // R9
   commit_with_byte_chk: assert property (@(posedge clk) disable iff (rst)
      q_commit |-> q_valid);

   // R8
   no_commit_full_chk: assert property (@(posedge clk) disable iff (rst)
      q_commit |-> !$past(queue_full[q_sel]));

   // R7
   sel_range_chk: assert property (@(posedge clk) disable iff (rst)
      q_sel < 3'(NUM_Q));

   // R7
   sel_steady_chk: assert property (@(posedge clk) disable iff (rst)
      (q_valid && $past(q_valid) && !(rx_valid && rx_sof)) |-> $stable(q_sel));

endmodule

// File: tb/ipfwd_classifier_tb_top.sv
module ipfwd_classifier_tb_top;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [7:0]  rx_data = '0;
   logic        rx_valid = 1'b0, rx_sof = 1'b0, rx_eof = 1'b0;
   logic [31:0] router_ip   = 32'hC0A8_0502;
   logic [31:0] subnet_mask = 32'hFFFF_FF00;
   logic [4:0]  queue_full  = '0;
   logic [7:0]  q_data;
   logic        q_valid, q_commit, q_discard;
   logic [2:0]  q_sel;

   always #4 clk = ~clk;

   ipfwd_classifier dut_i (
      .clk(clk), .rst(rst), .rx_data(rx_data), .rx_valid(rx_valid),
      .rx_sof(rx_sof), .rx_eof(rx_eof), .router_ip(router_ip),
      .subnet_mask(subnet_mask), .queue_full(queue_full), .q_data(q_data),
      .q_valid(q_valid), .q_sel(q_sel), .q_commit(q_commit),
      .q_discard(q_discard)
   );

   int          n_chk = 0, n_bad = 0;
   logic [7:0]  fr [0:99];
   int          flen;
   logic [7:0]  got [$];
   logic        got_end, got_commit;
   logic [2:0]  got_sel;
   logic [15:0] fr_etype;
   logic [3:0]  fr_ver;
   logic [5:0]  fr_dscp;
   logic [7:0]  fr_ttl;
   logic [31:0] fr_dst;

   always @(negedge clk) begin
      if (!rst) begin
         if (q_valid) got.push_back(q_data);
         if (q_commit || q_discard) begin
            got_end    = 1'b1;
            got_commit = q_commit;
            got_sel    = q_sel;
         end
      end
   end

   task automatic check(input bit ok, input string req, input string what,
                        input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   function automatic logic [15:0] hdr_csum(input logic [7:0] h [0:19]);
      logic [16:0] s = '0;
      for (int i = 0; i < 10; i++) begin
         if (i != 5) s = {1'b0, s[15:0]} + {1'b0, h[2*i], h[2*i+1]} + {16'd0, s[16]};
      end
      s = {1'b0, s[15:0]} + {16'd0, s[16]};
      return ~s[15:0];
   endfunction

   function automatic logic [2:0] exp_queue(input logic [5:0] d);
      if (d == 6'b101110) return 3'd4;
      if (!d[0] && d[5:3] >= 1 && d[5:3] <= 4 && d[2:1] != 0) return d[5:3] - 3'd1;
      return 3'd0;
   endfunction

   task automatic build(input logic [5:0] dscp, input logic [7:0] ttl,
                        input logic [31:0] dst, input logic [15:0] etype,
                        input logic [3:0] ver, input int pay, input int cut);
      logic [7:0]  h [0:19];
      logic [15:0] c;
      fr_etype = etype; fr_ver = ver; fr_dscp = dscp; fr_ttl = ttl; fr_dst = dst;
      for (int i = 0; i < 12; i++) fr[i] = 8'($urandom);
      fr[12] = etype[15:8]; fr[13] = etype[7:0];
      for (int i = 0; i < 20; i++) h[i] = 8'($urandom);
      h[0] = {ver, 4'd5}; h[1] = {dscp, 2'b00};
      h[2] = 8'd0; h[3] = 8'(20 + pay); h[6] = 8'h40; h[7] = 8'h00;
      h[8] = ttl; h[9] = 8'd17;
      {h[16], h[17], h[18], h[19]} = dst;
      c = hdr_csum(h);
      h[10] = c[15:8]; h[11] = c[7:0];
      for (int i = 0; i < 20; i++) fr[14+i] = h[i];
      for (int i = 0; i < pay; i++) fr[34+i] = 8'($urandom);
      flen = (cut > 0) ? cut : 34 + pay;
   endtask

   task automatic send(input string tag, input bit gaps);
      logic [7:0]  e [0:19];
      logic [15:0] c;
      logic [2:0]  xq;
      bit          xf;
      int          bad_i;
      got.delete(); got_end = 1'b0; got_commit = 1'b0;
      for (int i = 0; i < flen; i++) begin
         if (gaps) while ($urandom % 3 == 0) begin
            @(posedge clk); #1; rx_valid = 1'b0;
         end
         @(posedge clk); #1;
         rx_valid = 1'b1; rx_data = fr[i];
         rx_sof = (i == 0); rx_eof = (i == flen - 1);
      end
      @(posedge clk); #1; rx_valid = 1'b0; rx_sof = 1'b0; rx_eof = 1'b0;
      for (int w = 0; w < 6 && !got_end; w++) @(posedge clk);
      @(negedge clk);
      xq = exp_queue(fr_dscp);
      xf = (fr_etype == 16'h0800) && (fr_ver == 4) && (flen >= 34) &&
           (fr_ttl != 0) && (fr_dst != 32'hFFFF_FFFF) &&
           ((fr_dst & subnet_mask) != (router_ip & subnet_mask)) && !queue_full[xq];
      check(got_end, "R9", "verdict pulse seen", got_end, 1);
      check(got_commit == xf, tag, "commit decision", got_commit, xf);
      check(got.size() == ((flen > 14) ? flen - 14 : 0), "R1", "IP byte count",
            got.size(), (flen > 14) ? flen - 14 : 0);
      if (xf && got.size() >= 20) begin
         for (int i = 0; i < 20; i++) e[i] = fr[14+i];
         e[8] = fr_ttl - 8'd1;
         c = hdr_csum(e);
         e[10] = c[15:8]; e[11] = c[7:0];
         check(got_sel == xq, "R7", "queue index", got_sel, xq);
         check(got[8] == e[8], "R3", "TTL byte", got[8], e[8]);
         check({got[10], got[11]} == c, "R4", "checksum", {got[10], got[11]}, c);
         bad_i = -1;
         for (int i = 0; i < got.size(); i++)
            if (bad_i < 0 && got[i] != ((i < 20) ? e[i] : fr[14+i])) bad_i = i;
         check(bad_i < 0, gaps ? "R10" : "R1", "byte content mismatch index",
               bad_i, -1);
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_bad++;
      $display("FAIL R9 watchdog expired: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      void'($urandom(32'd417));
      repeat (3) @(posedge clk);
      #1 rst = 1'b0;
      @(negedge clk);
      check(!q_valid && !q_commit && !q_discard, "R9", "reset outputs",
            {q_valid, q_commit, q_discard}, 0);

      // directed corners
      build(6'd0, 8'd64, 32'h4A36_6142, 16'h0800, 4'd4, 6, 0);  send("R1", 0);
      build(6'd0, 8'd64, 32'h4A36_6142, 16'h0806, 4'd4, 6, 0);  send("R2", 0);
      build(6'd0, 8'd64, 32'h4A36_6142, 16'h0800, 4'd6, 6, 0);  send("R2", 0);
      build(6'd0, 8'd0,  32'h4A36_6142, 16'h0800, 4'd4, 4, 0);  send("R3", 0);
      build(6'd0, 8'd1,  32'h4A36_6142, 16'h0800, 4'd4, 4, 0);  send("R3", 0);
      build(6'd0, 8'd255, 32'h4A36_6142, 16'h0800, 4'd4, 2, 0); send("R4", 0);
      build(6'd0, 8'd9,  32'hFFFF_FFFF, 16'h0800, 4'd4, 3, 0);  send("R5", 0);
      build(6'd0, 8'd9,  32'hC0A8_054D, 16'h0800, 4'd4, 3, 0);  send("R6", 0);
      build(6'd0, 8'd9,  32'hC0A8_0602, 16'h0800, 4'd4, 3, 0);  send("R6", 0);
      build(6'b101110, 8'd9, 32'h0A00_0001, 16'h0800, 4'd4, 0, 0); send("R7", 0);
      for (int cl = 1; cl <= 4; cl++)
         for (int dp = 1; dp <= 3; dp++) begin
            build(6'((cl << 3) | (dp << 1)), 8'd9, 32'h0A00_0001, 16'h0800, 4'd4, 1, 0);
            send("R7", 0);
         end
      build(6'b001111, 8'd9, 32'h0A00_0001, 16'h0800, 4'd4, 1, 0); send("R7", 0);
      build(6'b010000, 8'd9, 32'h0A00_0001, 16'h0800, 4'd4, 1, 0); send("R7", 0);
      queue_full = 5'b10000;
      build(6'b101110, 8'd9, 32'h0A00_0001, 16'h0800, 4'd4, 1, 0); send("R8", 0);
      build(6'b001010, 8'd9, 32'h0A00_0001, 16'h0800, 4'd4, 1, 0); send("R8", 0);
      queue_full = 5'b00000;
      build(6'd0, 8'd9, 32'h0A00_0001, 16'h0800, 4'd4, 0, 33); send("R9", 0);
      build(6'd0, 8'd9, 32'h0A00_0001, 16'h0800, 4'd4, 0, 10); send("R9", 0);
      build(6'd0, 8'd9, 32'h0A00_0001, 16'h0800, 4'd4, 0, 34); send("R9", 0);

      // constrained random
      for (int n = 0; n < 150; n++) begin
         logic [31:0] d;
         logic [15:0] et;
         logic [5:0]  ds;
         case ($urandom % 6)
            0:       d = {router_ip[31:8], 8'($urandom)};
            1:       d = 32'hFFFF_FFFF;
            default: d = $urandom;
         endcase
         et = ($urandom % 8 == 0) ? 16'h86DD : 16'h0800;
         ds = ($urandom % 4 == 0) ? 6'b101110 : 6'($urandom);
         queue_full = ($urandom % 5 == 0) ? 5'($urandom) : 5'd0;
         build(ds, 8'($urandom % 4 == 0 ? $urandom % 2 : $urandom), d, et,
               ($urandom % 10 == 0) ? 4'd5 : 4'd4, $urandom % 30, 0);
         send("R10", 1'($urandom % 2));
      end

      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

endmodule